// File: doc/BRIEF.md
# Shared Endpoint-to-Port Routing Table

This block is an associative lookup table shared by a set of ingress ports. Each port asks which output port serves a 16-bit destination endpoint identifier, and gets back a port index qualified by a hit flag. On a miss the requester substitutes its own failsafe port. The table holds a fixed number of mappings. Once it is full, each new mapping overwrites the one that was inserted earliest.

Lookups arrive on one valid/ready request stream per port and leave on one valid/ready result stream per port. A single round-robin arbiter admits at most one request per cycle. The result is registered and is held until the requester accepts it. A port whose result is still waiting is not granted again, so back-pressure on a result stream stalls only that port's requests.

Mappings are installed by write strobes. Each port has its own strobe, and an optional external strobe can also write. Every write carries a 16-bit address, which is the endpoint identifier, and 32-bit data, whose low bits are the destination port. Every write is answered by exactly one ack pulse. A write stays queued inside the block until it is applied. A writer holds off its next strobe until its ack arrives.

Top module: `epid_route_table`

## Requirements
- R1: Out of reset, the table is empty, no result is valid and no ack is asserted.
- R2: A write with address A and data D installs the mapping A → D[PORT_W-1:0], where PORT_W = log2(NUM_PORTS).
- R3: When a lookup is accepted (lk_valid and lk_ready both high at a clock edge), res_valid rises for that port after that edge. If the identifier is stored, res_hit is 1 and res_port carries the stored port.
- R4: A lookup of an identifier that is not stored returns res_hit = 0 and res_port = 0.
- R5: The table holds 2^TBL_LOG2 mappings. The next new identifier after that evicts the earliest inserted one, and the other mappings stay.
- R6: A write to an identifier already present changes its port in place and uses no new slot.
- R7: When an external write and a port write are pending in the same cycle, the external write is applied and acknowledged first.
- R8: Each write produces exactly one single-cycle ack on its own source's ack pin. At most one ack is high in any cycle. Simultaneous port writes are all applied, lowest port first.
- R9: At most one lookup is accepted per cycle. The arbiter grants the first requesting port after the one granted last, wrapping from the highest index to 0. After reset, port 0 has first turn.
- R10: While res_valid is high and res_ready is low for a port, that port's result stays stable and lk_ready stays low for that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_stb | input | NUM_PORTS | Per-port write strobe, one cycle per write |
| cfg_wr_addr | input | 16*NUM_PORTS | Per-port endpoint identifier to map |
| cfg_wr_data | input | 32*NUM_PORTS | Per-port write data; low PORT_W bits are the destination port |
| cfg_wr_ack | output | NUM_PORTS | Per-port write acknowledge pulse |
| ext_wr_stb | input | 1 | External write strobe (ignored when EXT_EN = 0) |
| ext_wr_addr | input | 16 | External endpoint identifier |
| ext_wr_data | input | 32 | External write data |
| ext_wr_ack | output | 1 | External write acknowledge pulse |
| lk_valid | input | NUM_PORTS | Lookup request valid per port |
| lk_ready | output | NUM_PORTS | Lookup request accepted per port |
| lk_epid | input | 16*NUM_PORTS | Endpoint identifier to look up per port |
| res_valid | output | NUM_PORTS | Result valid per port |
| res_ready | input | NUM_PORTS | Result accepted per port |
| res_hit | output | NUM_PORTS | 1 when the identifier was found |
| res_port | output | PORT_W*NUM_PORTS | Output port index found, 0 on a miss |

## Verification
The hardest situation to create from the ports is arbitration order. With every requester free, round-robin and fixed priority grant in the same order. The bench therefore first grants port 1 alone, then raises ports 0 and 2 together while holding their result streams stalled. The order in which the two results appear shows whether the grant rotated past port 1. Write priority and in-place update are reached in a similar way. Both strobes are driven on the same clock edge for one key with different ports, and one identifier is rewritten before the table fills, so that the eviction pattern shows the slot count.

// File: rtl/route_tbl_pkg.sv
package route_tbl_pkg;
  localparam int EPID_W = 16;
  localparam int CFG_D_W = 32;
  typedef logic [EPID_W-1:0] epid_t;
  typedef logic [CFG_D_W-1:0] cfg_data_t;
endpackage

// File: rtl/rt_rr_arbiter.sv
module rt_rr_arbiter #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;
  int            cand;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    cand    = 0;
    for (int k = 1; k <= N; k++) begin
      cand = (int'(last_q) + k) % N;
      if (!any && req[cand]) begin
        any       = 1'b1;
        gnt[cand] = 1'b1;
        gnt_idx   = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IW'(N - 1);
    else if (any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/rt_cfg_collect.sv
module rt_cfg_collect
  import route_tbl_pkg::*;
#(
  parameter int N      = 4,
  parameter bit EXT_EN = 1'b1,
  parameter int PW     = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N-1:0]          stb,
  input  logic [EPID_W*N-1:0]   addr,
  input  logic [CFG_D_W*N-1:0]  data,
  output logic [N-1:0]          ack,
  input  logic                  x_stb,
  input  epid_t                 x_addr,
  input  cfg_data_t             x_data,
  output logic                  x_ack,
  output logic                  wr_en,
  output epid_t                 wr_key,
  output logic [PW-1:0]         wr_port
);
  logic [N-1:0]  pend_q;
  epid_t         key_q [N];
  logic [PW-1:0] dst_q [N];
  logic          x_pend_q;
  epid_t         x_key_q;
  logic [PW-1:0] x_dst_q;
  logic [N-1:0]  pick;
  logic          pick_x;
  logic [N-1:0]  ack_q;
  logic          x_ack_q;

  // upper data bits carry no routing meaning
  logic unused_hi;
  always_comb begin
    unused_hi = ^x_data[CFG_D_W-1:PW];
    for (int i = 0; i < N; i++) unused_hi ^= ^data[i*CFG_D_W+PW +: CFG_D_W-PW];
  end

  // per-port request latches
  for (genvar i = 0; i < N; i++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
      end else if (stb[i]) begin
        pend_q[i] <= 1'b1;
      end else if (pick[i]) begin
        pend_q[i] <= 1'b0;
      end
      if (stb[i]) begin
        key_q[i] <= addr[i*EPID_W +: EPID_W];
        dst_q[i] <= data[i*CFG_D_W +: PW];
      end
    end
  end

  // external request latch, present only when enabled
  if (EXT_EN) begin : g_ext
    always_ff @(posedge clk) begin
      if (rst) x_pend_q <= 1'b0;
      else if (x_stb) x_pend_q <= 1'b1;
      else if (pick_x) x_pend_q <= 1'b0;
      if (x_stb) begin
        x_key_q <= x_addr;
        x_dst_q <= x_data[PW-1:0];
      end
    end
  end else begin : g_no_ext
    logic unused_x;
    assign unused_x = x_stb ^ (^x_addr) ^ (^x_data[PW-1:0]);
    assign x_pend_q = 1'b0;
    assign x_key_q  = '0;
    assign x_dst_q  = '0;
  end

  // external first, then the lowest pending port
  always_comb begin
    pick    = '0;
    pick_x  = x_pend_q;
    wr_en   = x_pend_q;
    wr_key  = x_key_q;
    wr_port = x_dst_q;
    for (int i = 0; i < N; i++) begin
      if (!wr_en && pend_q[i]) begin
        wr_en   = 1'b1;
        pick[i] = 1'b1;
        wr_key  = key_q[i];
        wr_port = dst_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= '0;
      x_ack_q <= 1'b0;
    end else begin
      ack_q   <= pick;
      x_ack_q <= pick_x;
    end
  end

  assign ack   = ack_q;
  assign x_ack = x_ack_q;
endmodule

// File: rtl/rt_cam_store.sv
module rt_cam_store
  import route_tbl_pkg::*;
#(
  parameter int TBL_LOG2 = 3,
  parameter int PW       = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  epid_t         wr_key,
  input  logic [PW-1:0] wr_port,
  input  epid_t         lk_key,
  output logic          lk_hit,
  output logic [PW-1:0] lk_port
);
  localparam int ENTRIES = 1 << TBL_LOG2;

  logic [ENTRIES-1:0]  vld_q;
  epid_t               key_q [ENTRIES];
  logic [PW-1:0]       dst_q [ENTRIES];
  logic [TBL_LOG2-1:0] fill_ptr_q;
  logic [ENTRIES-1:0]  wr_match;
  logic [ENTRIES-1:0]  lk_match;
  logic [TBL_LOG2-1:0] wr_idx;
  logic                wr_hit;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    assign wr_match[e] = vld_q[e] && (key_q[e] == wr_key);
    assign lk_match[e] = vld_q[e] && (key_q[e] == lk_key);
  end

  always_comb begin
    wr_hit = |wr_match;
    wr_idx = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (wr_match[e]) wr_idx = TBL_LOG2'(e);
  end

  // identifiers are unique, so at most one cell matches
  always_comb begin
    lk_hit  = |lk_match;
    lk_port = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (lk_match[e]) lk_port |= dst_q[e];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      fill_ptr_q <= '0;
    end else if (wr_en) begin
      if (wr_hit) begin
        dst_q[wr_idx] <= wr_port;
      end else begin
        key_q[fill_ptr_q] <= wr_key;
        dst_q[fill_ptr_q] <= wr_port;
        vld_q[fill_ptr_q] <= 1'b1;
        fill_ptr_q        <= fill_ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/epid_route_table.sv
module epid_route_table
  import route_tbl_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TBL_LOG2  = 3,
  parameter bit EXT_EN    = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_PORTS-1:0]             cfg_wr_stb,
  input  logic [16*NUM_PORTS-1:0]          cfg_wr_addr,
  input  logic [32*NUM_PORTS-1:0]          cfg_wr_data,
  output logic [NUM_PORTS-1:0]             cfg_wr_ack,
  input  logic                             ext_wr_stb,
  input  logic [15:0]                      ext_wr_addr,
  input  logic [31:0]                      ext_wr_data,
  output logic                             ext_wr_ack,
  input  logic [NUM_PORTS-1:0]             lk_valid,
  output logic [NUM_PORTS-1:0]             lk_ready,
  input  logic [16*NUM_PORTS-1:0]          lk_epid,
  output logic [NUM_PORTS-1:0]             res_valid,
  input  logic [NUM_PORTS-1:0]             res_ready,
  output logic [NUM_PORTS-1:0]             res_hit,
  output logic [$clog2(NUM_PORTS)*NUM_PORTS-1:0] res_port
);
  localparam int PORT_W = $clog2(NUM_PORTS);

  logic                 wr_en;
  epid_t                wr_key;
  logic [PORT_W-1:0]    wr_port;
  logic [NUM_PORTS-1:0] gnt;
  logic [PORT_W-1:0]    gnt_idx;
  logic                 gnt_any;
  epid_t                sel_key;
  logic                 tbl_hit;
  logic [PORT_W-1:0]    tbl_port;
  logic [NUM_PORTS-1:0] rv_q;
  logic [NUM_PORTS-1:0] rh_q;
  logic [PORT_W-1:0]    rp_q [NUM_PORTS];
  logic                 unused_idx;

  rt_cfg_collect #(.N(NUM_PORTS), .EXT_EN(EXT_EN), .PW(PORT_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .stb    (cfg_wr_stb),
    .addr   (cfg_wr_addr),
    .data   (cfg_wr_data),
    .ack    (cfg_wr_ack),
    .x_stb  (ext_wr_stb),
    .x_addr (ext_wr_addr),
    .x_data (ext_wr_data),
    .x_ack  (ext_wr_ack),
    .wr_en  (wr_en),
    .wr_key (wr_key),
    .wr_port(wr_port)
  );

  // a port with a result still waiting does not compete
  rt_rr_arbiter #(.N(NUM_PORTS)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .req    (lk_valid & ~rv_q),
    .gnt    (gnt),
    .gnt_idx(gnt_idx),
    .any    (gnt_any)
  );
  assign unused_idx = ^gnt_idx ^ gnt_any;
  assign lk_ready   = gnt;

  always_comb begin
    sel_key = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (gnt[i]) sel_key |= lk_epid[i*EPID_W +: EPID_W];
  end

  rt_cam_store #(.TBL_LOG2(TBL_LOG2), .PW(PORT_W)) u_cam (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_key (wr_key),
    .wr_port(wr_port),
    .lk_key (sel_key),
    .lk_hit (tbl_hit),
    .lk_port(tbl_port)
  );

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst) begin
        rv_q[i] <= 1'b0;
        rh_q[i] <= 1'b0;
        rp_q[i] <= '0;
      end else if (gnt[i]) begin
        rv_q[i] <= 1'b1;
        rh_q[i] <= tbl_hit;
        rp_q[i] <= tbl_port;
      end else if (res_ready[i]) begin
        rv_q[i] <= 1'b0;
      end
    end
    assign res_port[i*PORT_W +: PORT_W] = rp_q[i];
  end

  assign res_valid = rv_q;
  assign res_hit   = rh_q;
endmodule

// File: rtl/rt_table_checker.sv
module rt_table_checker #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  cfg_wr_ack,
  input logic          ext_wr_ack,
  input logic [N-1:0]  lk_valid,
  input logic [N-1:0]  lk_ready,
  input logic [N-1:0]  res_valid,
  input logic [N-1:0]  res_ready,
  input logic [N-1:0]  res_hit,
  input logic [PW*N-1:0] res_port
);
  AST_ONE_ACK: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_wr_ack, cfg_wr_ack})); // R8

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_valid & lk_ready)); // R9

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (res_valid[i] && !res_ready[i]) |=>
        (res_valid[i] && $stable(res_hit[i]) && $stable(res_port[i*PW +: PW]))); // R10

    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (rst)
      res_valid[i] |-> !lk_ready[i]); // R10

    AST_RESULT_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      $rose(res_valid[i]) |-> $past(lk_valid[i] && lk_ready[i])); // R3

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (res_valid[i] && !res_hit[i]) |-> (res_port[i*PW +: PW] == '0)); // R4
  end
endmodule

bind epid_route_table rt_table_checker #(.N(NUM_PORTS), .PW(PORT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr_ack(cfg_wr_ack),
  .ext_wr_ack(ext_wr_ack),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_hit   (res_hit),
  .res_port  (res_port)
);

// File: tb/epid_route_table_tb.sv
`timescale 1ns/1ps
module epid_route_table_tb;
  localparam int N  = 4;
  localparam int TL = 3;
  localparam int E  = 1 << TL;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    cfg_wr_stb = '0;
  logic [16*N-1:0] cfg_wr_addr = '0;
  logic [32*N-1:0] cfg_wr_data = '0;
  logic [N-1:0]    cfg_wr_ack;
  logic            ext_wr_stb = 1'b0;
  logic [15:0]     ext_wr_addr = '0;
  logic [31:0]     ext_wr_data = '0;
  logic            ext_wr_ack;
  logic [N-1:0]    lk_valid = '0;
  logic [N-1:0]    lk_ready;
  logic [16*N-1:0] lk_epid = '0;
  logic [N-1:0]    res_valid;
  logic [N-1:0]    res_ready = '0;
  logic [N-1:0]    res_hit;
  logic [PW*N-1:0] res_port;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ext_ack_cnt = 0;
  int ext_ack_cyc = 0;
  int prt_ack_cnt [N];
  int prt_ack_cyc [N];

  always #5 clk = ~clk;

  epid_route_table #(.NUM_PORTS(N), .TBL_LOG2(TL), .EXT_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr_stb(cfg_wr_stb), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .cfg_wr_ack(cfg_wr_ack),
    .ext_wr_stb(ext_wr_stb), .ext_wr_addr(ext_wr_addr), .ext_wr_data(ext_wr_data),
    .ext_wr_ack(ext_wr_ack),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_epid(lk_epid),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_port(res_port)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial for (int i = 0; i < N; i++) begin prt_ack_cnt[i] = 0; prt_ack_cyc[i] = 0; end

  always @(negedge clk) begin
    if (!rst) begin
      if (ext_wr_ack) begin ext_ack_cnt++; ext_ack_cyc = cyc; end
      for (int i = 0; i < N; i++)
        if (cfg_wr_ack[i]) begin prt_ack_cnt[i]++; prt_ack_cyc[i] = cyc; end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; cfg_wr_stb = '0; ext_wr_stb = 1'b0; lk_valid = '0; res_ready = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic ext_write(logic [15:0] key, int dst);
    @(posedge clk); #1;
    ext_wr_stb = 1'b1; ext_wr_addr = key; ext_wr_data = 32'hABCD_0000 | 32'(dst);
    @(posedge clk); #1 ext_wr_stb = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic port_write(int p, logic [15:0] key, int dst);
    @(posedge clk); #1;
    cfg_wr_stb[p] = 1'b1; cfg_wr_addr[p*16 +: 16] = key;
    cfg_wr_data[p*32 +: 32] = 32'h1234_5670 | 32'(dst);
    @(posedge clk); #1 cfg_wr_stb[p] = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic do_lookup(int p, logic [15:0] key, output int hit, output int prt);
    @(posedge clk); #1;
    lk_valid[p] = 1'b1; lk_epid[p*16 +: 16] = key;
    @(negedge clk);
    while (!lk_ready[p]) @(negedge clk);
    @(posedge clk); #1 lk_valid[p] = 1'b0;
    @(negedge clk);
    chk("R3", "result valid one edge after accept", int'(res_valid[p]), 1);
    hit = int'(res_hit[p]);
    prt = int'(res_port[p*PW +: PW]);
    res_ready[p] = 1'b1;
    @(posedge clk); #1 res_ready[p] = 1'b0;
  endtask

  task automatic t_reset();
    int h, pt;
    @(negedge clk);
    chk("R1", "res_valid after reset", int'(res_valid), 0);
    chk("R1", "acks after reset", int'({ext_wr_ack, cfg_wr_ack}), 0);
    do_lookup(0, 16'h0000, h, pt);
    chk("R1", "lookup in empty table hit", h, 0);
    do_lookup(2, 16'hFFFF, h, pt);
    chk("R1", "lookup in empty table hit", h, 0);
  endtask

  task automatic t_basic();
    int h, pt, a0;
    a0 = prt_ack_cnt[1];
    port_write(1, 16'h1234, 2);
    chk("R8", "one ack for one port write", prt_ack_cnt[1] - a0, 1);
    do_lookup(3, 16'h1234, h, pt);
    chk("R2", "installed key hit", h, 1);
    chk("R2", "installed key port", pt, 2);
    do_lookup(0, 16'h9999, h, pt);
    chk("R4", "absent key hit", h, 0);
    chk("R4", "absent key port", pt, 0);
  endtask

  task automatic t_priority();
    int h, pt, e0, p0, c1, c2, c3;
    e0 = ext_ack_cnt; p0 = prt_ack_cnt[0];
    @(posedge clk); #1;
    ext_wr_stb = 1'b1; ext_wr_addr = 16'h55AA; ext_wr_data = 32'd1;
    cfg_wr_stb[0] = 1'b1; cfg_wr_addr[15:0] = 16'h55AA; cfg_wr_data[31:0] = 32'd3;
    @(posedge clk); #1;
    ext_wr_stb = 1'b0; cfg_wr_stb = '0;
    repeat (6) @(posedge clk);
    chk("R8", "ext ack count", ext_ack_cnt - e0, 1);
    chk("R8", "port0 ack count", prt_ack_cnt[0] - p0, 1);
    chk("R7", "ext acked one cycle before port", prt_ack_cyc[0] - ext_ack_cyc, 1);
    do_lookup(1, 16'h55AA, h, pt);
    chk("R7", "port write applied last", pt, 3);
    // three port writes at once, lowest index first
    c1 = prt_ack_cnt[1]; c2 = prt_ack_cnt[2]; c3 = prt_ack_cnt[3];
    @(posedge clk); #1;
    for (int i = 1; i < N; i++) begin
      cfg_wr_addr[i*16 +: 16] = 16'h0A00 + 16'(i);
      cfg_wr_data[i*32 +: 32] = 32'(i);
    end
    cfg_wr_stb = 4'b1110;
    @(posedge clk); #1 cfg_wr_stb = '0;
    repeat (6) @(posedge clk);
    chk("R8", "port1 ack count", prt_ack_cnt[1] - c1, 1);
    chk("R8", "port2 ack count", prt_ack_cnt[2] - c2, 1);
    chk("R8", "port3 ack count", prt_ack_cnt[3] - c3, 1);
    chk("R8", "port2 acked after port1", prt_ack_cyc[2] - prt_ack_cyc[1], 1);
    chk("R8", "port3 acked after port2", prt_ack_cyc[3] - prt_ack_cyc[2], 1);
    for (int i = 1; i < N; i++) begin
      do_lookup(0, 16'h0A00 + 16'(i), h, pt);
      chk("R8", "simultaneous write stored", pt, i);
    end
  endtask

  task automatic t_capacity();
    int h, pt;
    do_reset();
    for (int i = 0; i <= E; i++) ext_write(16'h0100 + 16'(i), i % N);
    do_lookup(0, 16'h0100, h, pt);
    chk("R5", "oldest evicted", h, 0);
    do_lookup(1, 16'h0101, h, pt);
    chk("R5", "second oldest kept", h, 1);
    chk("R5", "second oldest port", pt, 1);
    do_lookup(2, 16'h0100 + 16'(E), h, pt);
    chk("R5", "newest kept", h, 1);
    chk("R5", "newest port", pt, E % N);
  endtask

  task automatic t_inplace();
    int h, pt;
    do_reset();
    ext_write(16'h0200, 1);
    port_write(2, 16'h0200, 2);
    for (int i = 1; i < E; i++) ext_write(16'h0200 + 16'(i), 3);
    do_lookup(0, 16'h0200, h, pt);
    chk("R6", "rewritten key still present", h, 1);
    chk("R6", "rewritten key port updated", pt, 2);
    do_lookup(3, 16'h0200 + 16'(E - 1), h, pt);
    chk("R6", "last key present", h, 1);
  endtask

  task automatic t_arbiter();
    int h, pt, held;
    do_reset();
    ext_write(16'h0300, 1);
    ext_write(16'h0301, 2);
    do_lookup(1, 16'h0300, h, pt);
    @(posedge clk); #1;
    lk_epid[0 +: 16] = 16'h0300; lk_epid[32 +: 16] = 16'h0301;
    lk_valid = 4'b0101;
    @(negedge clk);
    chk("R9", "port2 granted before port0", int'(lk_ready), 4'b0100);
    @(posedge clk); #1 lk_valid[2] = 1'b0;
    @(negedge clk);
    chk("R9", "port2 result first", int'(res_valid), 4'b0100);
    chk("R9", "port0 granted next", int'(lk_ready), 4'b0001);
    @(posedge clk); #1 lk_valid[0] = 1'b0;
    @(negedge clk);
    chk("R9", "both results present", int'(res_valid), 4'b0101);
    chk("R3", "port2 result port", int'(res_port[2*PW +: PW]), 2);
    chk("R3", "port0 result port", int'(res_port[0 +: PW]), 1);
    // port2 stalled: new request must wait, result held
    lk_epid[32 +: 16] = 16'h0300; lk_valid[2] = 1'b1;
    held = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (lk_ready[2] || !res_valid[2] || res_port[2*PW +: PW] != 2'd2) held++;
    end
    chk("R10", "stall cycles with change", held, 0);
    res_ready[2] = 1'b1;
    @(posedge clk); #1 res_ready[2] = 1'b0;
    @(negedge clk);
    chk("R10", "request accepted after result taken", int'(lk_ready[2]), 1);
    @(posedge clk); #1 lk_valid[2] = 1'b0;
    @(negedge clk);
    chk("R10", "new result port", int'(res_port[2*PW +: PW]), 1);
    res_ready = 4'b1111;
    @(posedge clk); #1 res_ready = '0;
  endtask

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_priority();
    t_capacity();
    t_inplace();
    t_arbiter();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule